// File: doc/BRIEF.md
# Stop-Mode Wake-Up Sequencer

This block runs the low-power stop state of a small processor core. While the core runs, a stop command gates the core clock off. The block also captures the prescaler choice that will pace the later oscillator wait. Two events end the stop state: an asynchronous hardware reset, or an external interrupt request whose own enable line is high.

A reset returns the block straight to running, with its control state cleared. A wake by interrupt works differently. It starts an 8-bit interval counter at 00h, and that counter advances once per prescaler tick, with a divide of 2^(k+1) where k is the captured 3-bit select. The core clock stays gated until the counter overflows past FFh. The select must be chosen so that this wait exceeds the oscillator start-up time of about 20 ms.

After the wait, a single cycle tells the core how to continue. If the master interrupt flag is 1, the block pulses a take-vector strobe. If the flag is 0, it pulses a resume strobe, and the core continues at the instruction after the stop.

States:
- `ST_RUN`: the clock is on.
- `ST_STOP`: the clock is gated and the block waits for a wake event.
- `ST_STAB`: the clock is gated while the interval counter runs.
- `ST_RESUME`: one cycle with the clock on, in which one strobe is pulsed.

Transitions:
- RUN→STOP on an accepted stop command.
- STOP→STAB on an enabled synchronized request.
- STAB→RESUME on counter overflow.
- RESUME→RUN always.
- Any state→RUN on reset.

Top module: `stop_wake_seq`

## Requirements
- R1: Reset is asynchronous and acts from any state. While it is low, and after its release, `clk_en` is 1 and both strobes are 0. The block stays running, with no strobe, until a stop command arrives.
- R2: When `stop_req` is 1 in RUN, `clk_en` is 0 from the next clock edge. It stays 0 while no enabled interrupt request is present.
- R3: A request on a line whose `irq_en` bit is 0 does not wake the block. `clk_en` stays 0.
- R4: Each `irq_req` line passes through two synchronizing flops. When an enabled request rises while the block is stopped, the stabilization wait begins on the third clock edge after the request rises.
- R5: The stabilization wait lasts exactly 256·2^(k+1) cycles, with `clk_en` held at 0 throughout. Here k is the value of `psc_sel` sampled when the stop command was accepted. Later changes to `psc_sel` have no effect.
- R6: At the end of the wait, with `master_ie` at 0, `resume_stb` is 1 for exactly one cycle and `clk_en` is 1 in that cycle.
- R7: At the end of the wait, with `master_ie` at 1, `vector_stb` is 1 for exactly one cycle, instead of `resume_stb`.
- R8: A `stop_req` outside RUN is ignored. A pulse during the wait changes neither its length nor its outcome.
- R9: The two strobes are never 1 together, and neither is 1 in two consecutive cycles. After a strobe the block is back in RUN with `clk_en` at 1.
- R10: If an enabled synchronized request is already present when the stop command is accepted, the wait begins on the next edge. The strobe then appears 2+256·2^(k+1) edges after the stop command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| stop_req | input | 1 | Stop command from the core |
| irq_req | input | NUM_IRQ | External interrupt request lines (asynchronous) |
| irq_en | input | NUM_IRQ | Per-line interrupt enable bits |
| master_ie | input | 1 | Master interrupt enable flag |
| psc_sel | input | SEL_W | Prescaler select k, divide 2^(k+1) |
| clk_en | output | 1 | Core clock enable, 0 while gated |
| resume_stb | output | 1 | One-cycle strobe: continue with the next instruction |
| vector_stb | output | 1 | One-cycle strobe: take the interrupt vector |

## Verification
Two functions can fall in the same cycle: accepting a stop command and detecting an enabled wake request. The bench provokes this by holding an enabled request high and synchronized before it raises `stop_req`. The result is judged by the exact edge count to the strobe: it must be one edge shorter than a wake from an idle stop. A second overlap is a stop command arriving in the middle of the stabilization count. The bench pulses `stop_req` there and requires an unchanged wait length and outcome.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STOP   = 2'd1,
        ST_STAB   = 2'd2,
        ST_RESUME = 2'd3
    } wake_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int NUM_IRQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] req_async,
    output logic [NUM_IRQ-1:0] req_sync
);
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= req_async[i];
                sync_q <= meta_q;
            end
        end
        assign req_sync[i] = sync_q;
    end
endmodule

// File: rtl/wake_prescaler.sv
module wake_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = 2 ** SEL_W;

    logic [DIV_W-1:0] pcnt_q;
    logic [DIV_W-1:0] mask;

    // divide 2^(sel+1): tick when the low sel+1 bits are all ones
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i <= int'(sel));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (!run) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    assign tick = run && ((pcnt_q & mask) == mask);
endmodule

// File: rtl/interval_counter.sv
module interval_counter #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic ovf
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ovf = run && tick && (cnt_q == {CNT_W{1'b1}});
endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
    import stop_wake_pkg::*;
#(
    parameter int NUM_IRQ = 4,
    parameter int SEL_W   = 3,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stop_req,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               master_ie,
    input  logic [SEL_W-1:0]   psc_sel,
    output logic               clk_en,
    output logic               resume_stb,
    output logic               vector_stb
);
    wake_state_t      state_q;
    wake_state_t      state_d;
    logic [SEL_W-1:0] sel_q;
    logic [NUM_IRQ-1:0] irq_s;
    logic             wake_hit;
    logic             stab_run;
    logic             psc_tick;
    logic             cnt_ovf;

    irq_sync #(.NUM_IRQ(NUM_IRQ)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (irq_req),
        .req_sync  (irq_s)
    );

    assign wake_hit = |(irq_s & irq_en);
    assign stab_run = (state_q == ST_STAB);

    wake_prescaler #(.SEL_W(SEL_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (stab_run),
        .sel   (sel_q),
        .tick  (psc_tick)
    );

    interval_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (stab_run),
        .tick  (psc_tick),
        .ovf   (cnt_ovf)
    );

    // state register and captured prescaler select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && stop_req) begin
                sel_q <= psc_sel;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (stop_req) state_d = ST_STOP;
            ST_STOP:   if (wake_hit) state_d = ST_STAB;
            ST_STAB:   if (cnt_ovf)  state_d = ST_RESUME;
            ST_RESUME: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // output decode
    always_comb begin
        clk_en     = 1'b1;
        resume_stb = 1'b0;
        vector_stb = 1'b0;
        unique case (state_q)
            ST_RUN:    clk_en = 1'b1;
            ST_STOP:   clk_en = 1'b0;
            ST_STAB:   clk_en = 1'b0;
            ST_RESUME: begin
                vector_stb = master_ie;
                resume_stb = !master_ie;
            end
            default:   clk_en = 1'b1;
        endcase
    end
endmodule

// File: rtl/stop_wake_chk.sv
module stop_wake_chk
    import stop_wake_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        stop_req,
    input logic        master_ie,
    input logic        clk_en,
    input logic        resume_stb,
    input logic        vector_stb,
    input logic        ovf,
    input wake_state_t state
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(resume_stb && vector_stb)); // R9
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_stb || vector_stb) |=> !(resume_stb || vector_stb)); // R9
    AST_STOP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && stop_req) |=> !clk_en); // R2
    AST_OVF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (resume_stb || vector_stb)); // R5
    AST_GATED_BEFORE: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_stb || vector_stb) |-> !$past(clk_en)); // R5
    AST_STROBE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_stb || vector_stb) |-> clk_en); // R6
    AST_RESUME_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        resume_stb |-> !master_ie); // R6
    AST_VECTOR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        vector_stb |-> master_ie); // R7
    AST_STOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STAB && stop_req && !ovf) |=> !clk_en); // R8
endmodule

bind stop_wake_seq stop_wake_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .master_ie  (master_ie),
    .clk_en     (clk_en),
    .resume_stb (resume_stb),
    .vector_stb (vector_stb),
    .ovf        (cnt_ovf),
    .state      (state_q)
);

// File: tb/sim_stop_wake_seq.sv
`timescale 1ns/1ps
module sim_stop_wake_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0;
    logic [3:0] irq_req = '0;
    logic [3:0] irq_en = '0;
    logic       master_ie = 1'b0;
    logic [2:0] psc_sel = '0;
    logic       clk_en;
    logic       resume_stb;
    logic       vector_stb;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stop_wake_seq u0 (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .irq_req(irq_req),
        .irq_en(irq_en), .master_ie(master_ie), .psc_sel(psc_sel),
        .clk_en(clk_en), .resume_stb(resume_stb), .vector_stb(vector_stb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        stop_req = 1'b0;
        irq_req = '0;
        irq_en = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // counts negedges from now until a strobe is seen; checks gating meanwhile
    task automatic measure(input int exp_n, input bit exp_vec, input string req,
                           input int pulse_at);
        int n = 0;
        bit gated_ok = 1'b1;
        while (n < 70000) begin
            @(negedge clk);
            n++;
            if (n == pulse_at) stop_req = 1'b1;
            if (n == pulse_at + 1) stop_req = 1'b0;
            if (resume_stb || vector_stb) break;
            if (clk_en) gated_ok = 1'b0;
        end
        check(n == exp_n, {req, " wait length"}, n, exp_n);
        check(gated_ok, {req, " clock gated during wait"}, 0, 0);
        check(vector_stb == exp_vec && resume_stb == !exp_vec,
              {req, " strobe kind"}, int'(vector_stb), int'(exp_vec));
        check(clk_en == 1'b1, {req, " clk_en in strobe cycle"}, int'(clk_en), 1);
        @(negedge clk);
        check(!resume_stb && !vector_stb && clk_en, {req, " R9 single strobe, back in run"},
              int'(resume_stb) + int'(vector_stb), 0);
    endtask

    task automatic enter_stop(input logic [2:0] k);
        @(negedge clk);
        psc_sel = k;
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        check(clk_en == 1'b0, "R2 gated after stop", int'(clk_en), 0);
    endtask

    task automatic t_reset_state();
        check(clk_en == 1'b1 && !resume_stb && !vector_stb, "R1 reset state", int'(clk_en), 1);
        repeat (20) @(negedge clk);
        check(clk_en == 1'b1 && !resume_stb && !vector_stb, "R1 idle run", int'(clk_en), 1);
    endtask

    task automatic t_disabled_then_resume();
        enter_stop(3'd0);
        psc_sel = 3'd5; // R5: change after capture must not matter
        irq_en = 4'b0010;
        irq_req = 4'b0001;
        repeat (50) @(negedge clk);
        check(clk_en == 1'b0, "R3 disabled request keeps stop", int'(clk_en), 0);
        check(clk_en == 1'b0, "R2 stays gated", int'(clk_en), 0);
        master_ie = 1'b0;
        irq_req = 4'b0011;
        measure(3 + 512, 1'b0, "R4 R5 R6", -10);
        irq_req = '0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_vector();
        enter_stop(3'd1);
        irq_en = 4'b1000;
        master_ie = 1'b1;
        repeat (4) @(negedge clk);
        irq_req = 4'b1000;
        measure(3 + 1024, 1'b1, "R7", -10);
        irq_req = '0;
        master_ie = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_stop_ignored();
        enter_stop(3'd0);
        irq_en = 4'b0100;
        repeat (4) @(negedge clk);
        irq_req = 4'b0100;
        measure(3 + 512, 1'b0, "R8 stop pulse during wait", 200);
        irq_req = '0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_pending_at_stop();
        irq_en = 4'b0001;
        irq_req = 4'b0001;
        repeat (5) @(negedge clk);
        check(clk_en == 1'b1, "R10 pending request ignored in run", int'(clk_en), 1);
        psc_sel = 3'd0;
        stop_req = 1'b1;
        fork
            begin
                @(negedge clk);
                stop_req = 1'b0;
            end
        join_none
        measure(2 + 512, 1'b0, "R10 same-cycle wake", -10);
        irq_req = '0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset_mid_wait();
        bit strobe_seen = 1'b0;
        enter_stop(3'd2);
        irq_en = 4'b0001;
        irq_req = 4'b0001;
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(clk_en == 1'b1 && !resume_stb && !vector_stb, "R1 async reset in wait",
              int'(clk_en), 1);
        irq_req = '0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (resume_stb || vector_stb || !clk_en) strobe_seen = 1'b1;
        end
        check(!strobe_seen, "R1 no strobe after reset release", int'(strobe_seen), 0);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_disabled_then_resume();
        t_vector();
        t_stop_ignored();
        t_pending_at_stop();
        t_reset_mid_wait();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule